// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block produces the system reset for a processor subsystem. It takes two inputs. One is a digitized supply-good level from an external threshold comparator. The other is an active-low manual reset request, which may come from a push button or from a watchdog timeout line. From these it drives a pair of complementary reset outputs, one active-high and one active-low. Both inputs are brought into the clock domain through two-flop synchronizers. All timing is counted in cycles of a free-running clock.

While a fault is present, reset is held asserted. A fault is a supply-low indication or a low manual request. When the supply recovers, reset stays asserted for a release delay of `REL_CYC` cycles. When only the manual request is released, reset stays asserted for at least `MIN_CYC` cycles. A manual request never shortens a longer stretch that is already running. A supply dip always restarts the full release delay, so every reset pulse is at least the minimum width. The same stretch makes a bouncing switch give one clean pulse, so no separate debouncer is needed. `MIN_CYC` must not exceed `REL_CYC`.

Top module: `rst_pulse_gen`

## Requirements
- R1: While `rst` is high, and afterwards until the stretch expires, `sys_rst_o` is 1 and `sys_rst_n_o` is 0. With both inputs good, the outputs deassert exactly `REL_CYC`+3 clock edges after the last edge with `rst` high.
- R2: A low on `supply_ok_i` asserts `sys_rst_o` on the third clock edge after it is first sampled: two synchronizer stages, then the output register.
- R3: After `supply_ok_i` returns high with `man_rst_n_i` high, `sys_rst_o` falls exactly `REL_CYC`+3 edges after the first edge that samples the high level.
- R4: A supply dip that is sampled low for one clock edge while the system is running gives one reset pulse of exactly `REL_CYC`+1 cycles, then releases.
- R5: A low on `man_rst_n_i` asserts reset with a latency of 3 edges. When it is released and no longer stretch is running, reset falls exactly `MIN_CYC`+3 edges after the first edge that samples the high level.
- R6: A bouncing manual input (several low/high toggles) gives one continuous pulse. It ends `MIN_CYC`+3 edges after the final release.
- R7: A supply dip during an ongoing manual reset extends the pulse. The release delay counts from the supply recovery, even when the manual request is released first.
- R8: A short manual press during a supply-recovery stretch longer than `MIN_CYC` does not change the deassertion edge. That edge stays at `REL_CYC`+3 edges after the supply recovery.
- R9: `sys_rst_n_o` is always the exact complement of `sys_rst_o`.
- R10: A manual press sampled low for a single edge gives a pulse of exactly `MIN_CYC`+1 cycles. No pulse is shorter than this minimum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset of the block's own logic |
| supply_ok_i | input | 1 | Supply above threshold when 1 (asynchronous) |
| man_rst_n_i | input | 1 | Manual or watchdog reset request, active low (asynchronous) |
| sys_rst_o | output | 1 | System reset, active high |
| sys_rst_n_o | output | 1 | System reset, active low |

## Verification
The bench measures exact deassertion edges, not just the eventual level. An off-by-one in the synchronizer or in the counter reload would move the release by a cycle. Single-cycle dips on either input test the minimum-width floor. A design that counted from the start of the fault, or that deasserted with the fault, would give a pulse only a few cycles long. Overlap cases go after the reload priority. If a manual press replaced a longer supply stretch with the shorter minimum, reset would end too early. If a manual release cut off a stretch started by a brownout, the pulse would be truncated. Bounce trains check that toggling gives one pulse and not several.

// File: rtl/rsg_pkg.sv
package rsg_pkg;

    // Synchronized fault view that drives the stretch logic
    typedef struct packed {
        logic supply_low;
        logic manual;
    } fault_t;

    typedef enum logic [1:0] {
        PH_HOLD    = 2'd0,
        PH_STRETCH = 2'd1,
        PH_RUN     = 2'd2
    } phase_e;

    function automatic logic any_fault(input fault_t f);
        return f.supply_low | f.manual;
    endfunction

endpackage

// File: rtl/rsg_sync.sv
module rsg_sync #(
    parameter int   W       = 2,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= {STAGES{RST_VAL}};
            else     chain <= {chain[STAGES-2:0], d_i[b]};
        end
        assign q_o[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/rsg_stretch.sv
module rsg_stretch
    import rsg_pkg::*;
#(
    parameter int REL_CYC = 10_000_000,
    parameter int MIN_CYC = 7_000_000
) (
    input  logic   clk,
    input  logic   rst,
    input  fault_t flt_i,
    output logic   rst_q_o,
    output logic   rst_n_q_o,
    output phase_e phase_o
);
    localparam int CNT_W = $clog2(REL_CYC + 1);
    localparam logic [CNT_W-1:0] REL_V = CNT_W'(REL_CYC);
    localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_CYC);

    logic [CNT_W-1:0] cnt, cnt_nx;
    logic             hold;

    // Supply fault restarts the full delay; manual fault only sets a floor
    always_comb begin
        if (flt_i.supply_low)  cnt_nx = REL_V;
        else if (flt_i.manual) cnt_nx = (cnt > MIN_V) ? cnt - 1'b1 : MIN_V;
        else                   cnt_nx = (cnt != '0) ? cnt - 1'b1 : '0;
    end

    assign hold = any_fault(flt_i) | (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= REL_V;
            rst_q_o   <= 1'b1;
            rst_n_q_o <= 1'b0;
        end else begin
            cnt       <= cnt_nx;
            rst_q_o   <= hold;
            rst_n_q_o <= ~hold;
        end
    end

    always_comb begin
        if (any_fault(flt_i)) phase_o = PH_HOLD;
        else if (cnt != '0)   phase_o = PH_STRETCH;
        else                  phase_o = PH_RUN;
    end

    AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        any_fault(flt_i) |=> rst_q_o); // R2
    AST_SUPPLY_RELOAD: assert property (@(posedge clk) disable iff (rst)
        flt_i.supply_low |=> (cnt == REL_V)); // R7
    AST_MIN_FLOOR: assert property (@(posedge clk) disable iff (rst)
        (flt_i.manual && !flt_i.supply_low) |=> (cnt >= MIN_V)); // R10
    AST_NO_EARLY_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (rst_q_o && (cnt != '0)) |=> rst_q_o); // R8
endmodule

// File: rtl/rst_pulse_gen.sv
module rst_pulse_gen
    import rsg_pkg::*;
#(
    parameter int REL_CYC = 10_000_000,
    parameter int MIN_CYC = 7_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok_i,
    input  logic man_rst_n_i,
    output logic sys_rst_o,
    output logic sys_rst_n_o
);
    logic [1:0] raw, synced;
    fault_t     flt;
    phase_e     phase;

    assign raw = {supply_ok_i, man_rst_n_i};

    // Reset value 0 means both inputs read as faulted out of logic reset
    rsg_sync #(.W(2), .STAGES(2), .RST_VAL(1'b0)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw),
        .q_o (synced)
    );

    assign flt.supply_low = ~synced[1];
    assign flt.manual     = ~synced[0];

    rsg_stretch #(.REL_CYC(REL_CYC), .MIN_CYC(MIN_CYC)) u_stretch (
        .clk       (clk),
        .rst       (rst),
        .flt_i     (flt),
        .rst_q_o   (sys_rst_o),
        .rst_n_q_o (sys_rst_n_o),
        .phase_o   (phase)
    );

    AST_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
        sys_rst_o != sys_rst_n_o); // R9
    AST_RUN_IS_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RUN && $past(phase) == PH_RUN) |-> !sys_rst_o); // R3
endmodule

// File: tb/rst_pulse_gen_tb_top.sv
module rst_pulse_gen_tb_top;
    localparam int REL = 40;
    localparam int MIN = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sup_ok = 1'b1;
    logic mr_n = 1'b1;
    logic rst_o, rst_n_o;
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    always #2.5 clk = ~clk;

    rst_pulse_gen #(.REL_CYC(REL), .MIN_CYC(MIN)) dut_i (
        .clk(clk), .rst(rst), .supply_ok_i(sup_ok), .man_rst_n_i(mr_n),
        .sys_rst_o(rst_o), .sys_rst_n_o(rst_n_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Counts edges until reset reads low at a negedge; caller is at a negedge
    task automatic edges_to_release(output int n);
        n = 0;
        do begin
            @(posedge clk); n++;
            @(negedge clk);
            if (rst_o == rst_n_o) begin
                errors++;
                $display("FAIL R9 actual=%0d expected=%0d", rst_n_o, !rst_o);
            end
        end while (rst_o && n < 500);
    endtask

    task automatic idle(input int c);
        repeat (c) @(negedge clk);
    endtask

    task automatic t_reset_state();
        int n;
        @(negedge clk);
        chk("R1 rst_o during reset", rst_o, 1);
        chk("R1 rst_n_o during reset", rst_n_o, 0);
        rst = 1'b0;
        edges_to_release(n);
        chk("R1 release after logic reset", n, REL + 3);
        chk("R9 complement after release", rst_n_o, 1);
    endtask

    task automatic t_supply_low_recover();
        int n;
        sup_ok = 1'b0;
        idle(2);
        chk("R2 not yet asserted", rst_o, 0);
        idle(1);
        chk("R2 asserted on third edge", rst_o, 1);
        idle(30);
        chk("R2 held while supply low", rst_o, 1);
        sup_ok = 1'b1;
        edges_to_release(n);
        chk("R3 release delay", n, REL + 3);
    endtask

    task automatic t_brownout_pulse();
        int n, w;
        idle(5);
        sup_ok = 1'b0;
        idle(1);
        sup_ok = 1'b1;
        // sampled low at edge P+1 only; output rises at P+3
        idle(2);
        chk("R4 pulse started", rst_o, 1);
        w = 1;
        while (rst_o && w < 500) begin idle(1); if (rst_o) w++; end
        chk("R4 brownout pulse width", w, REL + 1);
        idle(5);
        chk("R4 not permanent", rst_o, 0);
    endtask

    task automatic t_manual();
        int n;
        idle(3);
        mr_n = 1'b0;
        idle(3);
        chk("R5 manual asserts in 3 edges", rst_o, 1);
        idle(60);
        chk("R5 manual held (watchdog feed)", rst_o, 1);
        mr_n = 1'b1;
        edges_to_release(n);
        chk("R5 manual release delay", n, MIN + 3);
    endtask

    task automatic t_bounce();
        int n;
        idle(3);
        for (int i = 0; i < 4; i++) begin
            mr_n = 1'b0; idle(2);
            mr_n = 1'b1; idle(3);
        end
        mr_n = 1'b0; idle(1);
        chk("R6 bounce keeps reset", rst_o, 1);
        mr_n = 1'b1;
        edges_to_release(n);
        chk("R6 release after last bounce", n, MIN + 3);
    endtask

    task automatic t_brownout_in_manual();
        int n;
        idle(3);
        mr_n = 1'b0;
        idle(20);
        sup_ok = 1'b0;
        idle(4);
        sup_ok = 1'b1;
        idle(2);
        mr_n = 1'b1;
        edges_to_release(n);
        chk("R7 release counted from supply recovery", n + 2, REL + 3);
    endtask

    task automatic t_press_in_stretch();
        int n;
        idle(3);
        sup_ok = 1'b0;
        idle(10);
        sup_ok = 1'b1;
        idle(5);
        mr_n = 1'b0;
        idle(1);
        mr_n = 1'b1;
        edges_to_release(n);
        chk("R8 press does not shorten stretch", n + 6, REL + 3);
    endtask

    task automatic t_min_width();
        int w;
        idle(5);
        mr_n = 1'b0;
        idle(1);
        mr_n = 1'b1;
        idle(2);
        chk("R10 glitch produces pulse", rst_o, 1);
        w = 1;
        while (rst_o && w < 500) begin idle(1); if (rst_o) w++; end
        chk("R10 minimum pulse width", w, MIN + 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset_state();
        t_supply_low_recover();
        t_brownout_pulse();
        t_manual();
        t_bounce();
        t_brownout_in_manual();
        t_press_in_stretch();
        t_min_width();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule